// File: doc/BRIEF.md
# Posted-Write Clock-Domain Register Bridge

This block connects a request/acknowledge register bus in a fast host clock domain to a small set of configuration registers that live in a slower timer clock domain. Each configuration register keeps a host-side shadow copy for reads. A delivery channel carries every write across to the timer domain as a toggle. Bit 0 of register 0 chooses how a write is acknowledged.

In posted mode the bus gets its acknowledge right away. The value then crosses to the timer domain in the background, and a per-register pending flag can be read from a status address. If the host writes again to a register whose value is still waiting to be sent, the waiting value is replaced without any error. In non-posted mode the acknowledge is held back until the timer-side register has captured the value and that completion has come back to the host domain.

A free-running count of timer clock rising edges is kept in the host domain, so it can be read without any crossing delay. The timer clock must run at no more than one quarter of the host clock frequency.

Top module: `posted_reg_bridge`

## Requirements
- R1: A request is held by the host until acknowledged. The acknowledge is a single-cycle pulse. A read is acknowledged in the cycle after acceptance, and the read data is valid in the acknowledge cycle.
- R2: When bit 0 of register 0 is 1 (posted mode), a write to any of the registers at addresses 0 to 3 is acknowledged in the cycle after acceptance. The value later appears on that register's timer-side output.
- R3: The read-only status register at address 4 holds the pending flag of register k in bit k. The flag is set from the cycle after a write is accepted and clears once the timer side has taken the value.
- R4: A write to a register whose earlier value has not yet been sent replaces that waiting value. The replaced value never appears on the timer-side output, and the timer-side register ends at the newest value.
- R5: When bit 0 of register 0 is 0 (non-posted mode), a register write is never acknowledged in the cycle after acceptance. By the acknowledge cycle, the timer-side output already holds the written value.
- R6: A read of addresses 0 to 3 returns the host-side copy, which is the last value written, even while its delivery is pending.
- R7: Address 5 returns the number of timer clock rising edges counted in the host domain, modulo 2^16. Between two reads, the difference matches the true edge count within one.
- R8: Reads of addresses 6 and 7 return zero with a normal acknowledge. Writes to addresses 4 to 7 are acknowledged and change nothing.
- R9: After reset, register 0 reads 1 (posted mode), registers 1 to 3 read 0, and all pending flags are clear. The timer-side outputs are 1, 0, 0, 0.
- R10: The acknowledge scheme for a write is chosen by the mode bit as it stood before that write, including writes to register 0 itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst_an | input | 1 | Host domain asynchronous reset, active low |
| tclk | input | 1 | Timer clock, at most a quarter of hclk |
| trst_an | input | 1 | Timer domain asynchronous reset, active low |
| host_req | input | 1 | Access request, held until acknowledged |
| host_we | input | 1 | 1 for write, 0 for read |
| host_addr | input | 3 | Register address |
| host_wdata | input | 16 | Write data |
| host_ack | output | 1 | Single-cycle acknowledge |
| host_rdata | output | 16 | Read data, valid with acknowledge |
| tmr_cfg | output | 64 | Timer-domain register values, register k in bits 16k+15..16k |

## Verification
Two events can land in the same host cycle: a new write to a register, and the completion of that register's earlier delivery, which frees the channel. The correct result is that the newest value is launched and any value still waiting is discarded. The bench provokes this with back-to-back and randomly spaced writes to the same register in both modes. It judges the outcome by the final timer-side value, by the fact that a deliberately overwritten value never shows up on the timer-side output, and by the timer-side value present when a non-posted acknowledge arrives.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_WAIT
  } host_st_e;
endpackage

// File: rtl/br_rst_sync.sv
module br_rst_sync (
  input  logic clk,
  input  logic rst_an,
  output logic rst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) begin
      stage_q <= 1'b0;
      rst_n   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_n   <= stage_q;
    end
  end
endmodule

// File: rtl/br_sync2.sv
module br_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      q      <= 1'b0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/br_reg_chan.sv
// One configuration register: host-side launch/queue logic and timer-side capture.
module br_reg_chan #(
  parameter int unsigned DW = 16,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          hclk,
  input  logic          hrst_n,
  input  logic          tclk,
  input  logic          trst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pend_o,
  output logic [DW-1:0] tval_o
);
  // host side
  logic          tgl_q, tgl_d;
  logic          queued_q, queued_d;
  logic [DW-1:0] hold_q, hold_d;
  logic [DW-1:0] next_q, next_d;
  logic          done_hs;
  logic          flight;

  // timer side
  logic          req_ts;
  logic          seen_q, seen_d;
  logic [DW-1:0] tval_q, tval_d;

  assign flight = tgl_q ^ done_hs;
  assign pend_o = flight | queued_q;

  always_comb begin
    tgl_d    = tgl_q;
    queued_d = queued_q;
    hold_d   = hold_q;
    next_d   = next_q;
    if (wr_i && !flight) begin
      // channel free: launch newest, drop anything waiting
      hold_d   = wdata_i;
      tgl_d    = ~tgl_q;
      queued_d = 1'b0;
    end else if (wr_i) begin
      next_d   = wdata_i;
      queued_d = 1'b1;
    end else if (!flight && queued_q) begin
      hold_d   = next_q;
      tgl_d    = ~tgl_q;
      queued_d = 1'b0;
    end
  end

  always_ff @(posedge hclk or negedge hrst_n) begin
    if (!hrst_n) begin
      tgl_q    <= 1'b0;
      queued_q <= 1'b0;
      hold_q   <= RST_VAL;
      next_q   <= '0;
    end else begin
      tgl_q    <= tgl_d;
      queued_q <= queued_d;
      hold_q   <= hold_d;
      next_q   <= next_d;
    end
  end

  br_sync2 u_req_sync (.clk(tclk), .rst_n(trst_n), .d(tgl_q), .q(req_ts));

  always_comb begin
    seen_d = req_ts;
    tval_d = (req_ts ^ seen_q) ? hold_q : tval_q;
  end

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      seen_q <= 1'b0;
      tval_q <= RST_VAL;
    end else begin
      seen_q <= seen_d;
      tval_q <= tval_d;
    end
  end

  assign tval_o = tval_q;

  br_sync2 u_done_sync (.clk(hclk), .rst_n(hrst_n), .d(seen_q), .q(done_hs));
endmodule

// File: rtl/posted_reg_bridge.sv
module posted_reg_bridge #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 4,
  parameter int unsigned AW   = 3,
  parameter int unsigned CW   = 16
) (
  input  logic               hclk,
  input  logic               hrst_an,
  input  logic               tclk,
  input  logic               trst_an,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [AW-1:0]      host_addr,
  input  logic [DW-1:0]      host_wdata,
  output logic               host_ack,
  output logic [DW-1:0]      host_rdata,
  output logic [NREG*DW-1:0] tmr_cfg
);
  import br_pkg::*;

  localparam int unsigned   IW       = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [AW-1:0] STAT_A   = AW'(NREG);
  localparam logic [AW-1:0] CNT_A    = AW'(NREG + 1);
  localparam logic [DW-1:0] CTRL_RST = DW'(1);

  logic            hrst_n, trst_n;
  host_st_e        st_q, st_d;
  logic            ack_q, ack_d;
  logic [DW-1:0]   rdata_q, rdata_d;
  logic [IW-1:0]   widx_q, widx_d;
  logic [DW-1:0]   shadow_q [NREG];
  logic [DW-1:0]   shadow_d [NREG];
  logic [NREG-1:0] wr_vec;
  logic [NREG-1:0] pend;
  logic            posted, idle, accept, is_cfg;
  logic [IW-1:0]   aidx;
  logic [DW-1:0]   rd_val;
  logic            tclk_s, tclk_q, tclk_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  br_rst_sync u_hrst (.clk(hclk), .rst_an(hrst_an), .rst_n(hrst_n));
  br_rst_sync u_trst (.clk(tclk), .rst_an(trst_an), .rst_n(trst_n));

  for (genvar g = 0; g < NREG; g++) begin : g_chan
    br_reg_chan #(
      .DW(DW),
      .RST_VAL((g == 0) ? CTRL_RST : '0)
    ) u_chan (
      .hclk(hclk), .hrst_n(hrst_n), .tclk(tclk), .trst_n(trst_n),
      .wr_i(wr_vec[g]), .wdata_i(host_wdata),
      .pend_o(pend[g]), .tval_o(tmr_cfg[g*DW +: DW])
    );
  end

  assign posted = shadow_q[0][0];
  assign idle   = (st_q == ST_IDLE);
  assign accept = host_req && !ack_q && idle;
  assign is_cfg = (host_addr < STAT_A);
  assign aidx   = host_addr[IW-1:0];

  always_comb begin
    if (is_cfg)                  rd_val = shadow_q[aidx];
    else if (host_addr == STAT_A) rd_val = DW'(pend);
    else if (host_addr == CNT_A)  rd_val = DW'(cnt_q);
    else                          rd_val = '0;
  end

  always_comb begin
    st_d     = st_q;
    ack_d    = 1'b0;
    rdata_d  = rdata_q;
    widx_d   = widx_q;
    wr_vec   = '0;
    shadow_d = shadow_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (!host_we) begin
            ack_d   = 1'b1;
            rdata_d = rd_val;
          end else if (!is_cfg) begin
            ack_d = 1'b1;
          end else begin
            wr_vec[aidx]   = 1'b1;
            shadow_d[aidx] = host_wdata;
            if (posted) begin
              ack_d = 1'b1;
            end else begin
              st_d   = ST_WAIT;
              widx_d = aidx;
            end
          end
        end
      end
      ST_WAIT: begin
        if (!pend[widx_q]) begin
          ack_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge hclk or negedge hrst_n) begin
    if (!hrst_n) begin
      st_q    <= ST_IDLE;
      ack_q   <= 1'b0;
      rdata_q <= '0;
      widx_q  <= '0;
      for (int i = 0; i < NREG; i++) shadow_q[i] <= (i == 0) ? CTRL_RST : '0;
    end else begin
      st_q    <= st_d;
      ack_q   <= ack_d;
      rdata_q <= rdata_d;
      widx_q  <= widx_d;
      for (int i = 0; i < NREG; i++) shadow_q[i] <= shadow_d[i];
    end
  end

  // timer edge count kept in the host domain
  br_sync2 u_tclk_sync (.clk(hclk), .rst_n(hrst_n), .d(tclk), .q(tclk_s));

  always_comb begin
    tclk_d = tclk_s;
    cnt_d  = (tclk_s && !tclk_q) ? cnt_q + CW'(1) : cnt_q;
  end

  always_ff @(posedge hclk or negedge hrst_n) begin
    if (!hrst_n) begin
      tclk_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      tclk_q <= tclk_d;
      cnt_q  <= cnt_d;
    end
  end

  assign host_ack   = ack_q;
  assign host_rdata = rdata_q;
endmodule

// File: rtl/br_checker.sv
module br_checker #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 4,
  parameter int unsigned AW   = 3,
  parameter int unsigned IW   = 2
) (
  input logic            hclk,
  input logic            hrst_n,
  input logic            host_req,
  input logic            host_we,
  input logic [AW-1:0]   host_addr,
  input logic            host_ack,
  input logic [DW-1:0]   host_rdata,
  input logic            posted,
  input logic            idle,
  input logic [NREG-1:0] pend
);
  logic take, cfg_hit, unmapped;
  assign take     = host_req && idle && !host_ack;
  assign cfg_hit  = int'(host_addr) < NREG;
  assign unmapped = int'(host_addr) > NREG + 1;

  assert_single_ack_R1: assert property (@(posedge hclk) disable iff (!hrst_n)
    host_ack |=> !host_ack);

  assert_posted_ack_R2: assert property (@(posedge hclk) disable iff (!hrst_n)
    (take && host_we && cfg_hit && posted) |=> host_ack);

  assert_pend_set_R3: assert property (@(posedge hclk) disable iff (!hrst_n)
    (take && host_we && cfg_hit) |=> pend[$past(host_addr[IW-1:0])]);

  assert_held_ack_R5: assert property (@(posedge hclk) disable iff (!hrst_n)
    (take && host_we && cfg_hit && !posted) |=> !host_ack);

  assert_unmapped_zero_R8: assert property (@(posedge hclk) disable iff (!hrst_n)
    (take && !host_we && unmapped) |=> (host_ack && host_rdata == '0));
endmodule

bind posted_reg_bridge br_checker #(
  .DW(DW), .NREG(NREG), .AW(AW), .IW(IW)
) u_br_checker (
  .hclk(hclk), .hrst_n(hrst_n), .host_req(host_req), .host_we(host_we),
  .host_addr(host_addr), .host_ack(host_ack), .host_rdata(host_rdata),
  .posted(posted), .idle(idle), .pend(pend)
);

// File: tb/test_posted_reg_bridge.sv
module test_posted_reg_bridge;
  localparam int DW = 16;
  localparam int NR = 4;

  logic hclk, tclk, hrst_an, trst_an;
  logic host_req, host_we;
  logic [2:0] host_addr;
  logic [DW-1:0] host_wdata;
  logic host_ack;
  logic [DW-1:0] host_rdata;
  logic [NR*DW-1:0] tmr_cfg;

  int nchk = 0;
  int nfail = 0;
  int tedges = 0;
  logic watch_on = 1'b0;
  logic [DW-1:0] forbid = '0;
  logic seen_forbid = 1'b0;
  logic [DW-1:0] model [NR];

  posted_reg_bridge i_posted_reg_bridge (
    .hclk(hclk), .hrst_an(hrst_an), .tclk(tclk), .trst_an(trst_an),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
    .tmr_cfg(tmr_cfg)
  );

  initial hclk = 1'b0;
  always #10 hclk = ~hclk;
  initial tclk = 1'b0;
  always #55 tclk = ~tclk;

  always @(posedge tclk) tedges <= tedges + 1;
  always @(negedge tclk)
    if (watch_on && tmr_cfg[1*DW +: DW] == forbid) seen_forbid <= 1'b1;

  function automatic logic [DW-1:0] tval(input int r);
    return tmr_cfg[r*DW +: DW];
  endfunction

  function automatic bit exp_posted(input logic [DW-1:0] ctrl);
    return ctrl[0];
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [DW-1:0] d, output int lat);
    @(negedge hclk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    lat = 0;
    do begin
      @(negedge hclk);
      lat++;
    end while (!host_ack && lat < 2000);
    host_req = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [DW-1:0] d, output int lat);
    @(negedge hclk);
    host_req = 1'b1; host_we = 1'b0; host_addr = a;
    lat = 0;
    do begin
      @(negedge hclk);
      lat++;
    end while (!host_ack && lat < 2000);
    d = host_rdata;
    host_req = 1'b0;
  endtask

  task automatic settle();
    repeat (80) @(negedge hclk);
  endtask

  initial begin
    repeat (150000) @(posedge hclk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    logic [DW-1:0] rd, a1, b1, c1, d0;
    int lat, e1, e2;
    logic [DW-1:0] v1, v2;
    int diff;
    void'($urandom(32'h5EED));
    host_req = 0; host_we = 0; host_addr = 0; host_wdata = 0;
    hrst_an = 0; trst_an = 0;
    repeat (6) @(negedge hclk);
    hrst_an = 1; trst_an = 1;
    repeat (20) @(negedge hclk);

    // R9 reset state
    bus_read(3'd0, rd, lat); chk(rd == 16'h1, "R9 ctrl reset", rd, 1);
    for (int r = 1; r < NR; r++) begin
      bus_read(3'(r), rd, lat); chk(rd == 0, "R9 reg reset", rd, 0);
    end
    bus_read(3'd4, rd, lat); chk(rd == 0, "R9 status reset", rd, 0);
    chk(tmr_cfg == 64'h1, "R9 timer outputs reset", tmr_cfg[31:0], 1);
    chk(lat == 1, "R1 read ack latency", lat, 1);

    // R2/R3/R6 posted write
    bus_write(3'd2, 16'h1234, lat); chk(lat == 1, "R2 posted ack", lat, 1);
    bus_read(3'd4, rd, lat); chk(rd[2] == 1'b1, "R3 pending set", rd, 4);
    bus_read(3'd2, rd, lat); chk(rd == 16'h1234, "R6 shadow read", rd, 16'h1234);
    settle();
    bus_read(3'd4, rd, lat); chk(rd == 0, "R3 pending clear", rd, 0);
    chk(tval(2) == 16'h1234, "R2 delivered", tval(2), 16'h1234);

    // R4 overwrite of a waiting value
    a1 = 16'hA111; b1 = 16'hB222; c1 = 16'hC333;
    forbid = b1; seen_forbid = 0; watch_on = 1;
    bus_write(3'd1, a1, lat);
    bus_write(3'd1, b1, lat);
    bus_write(3'd1, c1, lat);
    settle();
    watch_on = 0;
    chk(tval(1) == c1, "R4 newest delivered", tval(1), c1);
    chk(!seen_forbid, "R4 replaced value never seen", seen_forbid, 0);

    // R10 / R5 mode switching
    bus_write(3'd0, 16'h0, lat); chk(lat == 1, "R10 ctrl write uses old posted mode", lat, 1);
    bus_write(3'd3, 16'hBEEF, lat);
    chk(lat > 1, "R5 ack withheld", lat, 2);
    chk(tval(3) == 16'hBEEF, "R5 timer value at ack", tval(3), 16'hBEEF);
    bus_write(3'd0, 16'h1, lat);
    chk(lat > 1, "R10 ctrl write uses old non-posted mode", lat, 2);
    chk(tval(0) == 16'h1, "R5 ctrl at ack", tval(0), 1);

    // R7 counter
    bus_read(3'd5, v1, lat); e1 = tedges;
    repeat (300) @(negedge hclk);
    bus_read(3'd5, v2, lat); e2 = tedges;
    diff = int'(16'(v2 - v1)) - (e2 - e1);
    chk(diff >= -1 && diff <= 1, "R7 counter tracks timer edges", 16'(v2 - v1), e2 - e1);

    // R8 unmapped and ignored writes
    bus_read(3'd6, rd, lat); chk(rd == 0 && lat == 1, "R8 unmapped 6", rd, 0);
    bus_read(3'd7, rd, lat); chk(rd == 0 && lat == 1, "R8 unmapped 7", rd, 0);
    bus_write(3'd4, 16'h000F, lat); chk(lat == 1, "R8 ignored write ack", lat, 1);
    bus_read(3'd4, rd, lat); chk(rd == 0, "R8 status unchanged", rd, 0);

    // random mix, both modes
    for (int r = 0; r < NR; r++) begin
      bus_read(3'(r), rd, lat); model[r] = rd;
    end
    for (int k = 0; k < 80; k++) begin
      int r;
      bit pm;
      r = $urandom_range(0, NR - 1);
      d0 = 16'($urandom);
      pm = exp_posted(model[0]);
      bus_write(3'(r), d0, lat);
      if (pm) chk(lat == 1, "R2 random posted ack", lat, 1);
      else begin
        chk(lat > 1, "R5 random held ack", lat, 2);
        chk(tval(r) == d0, "R5 random timer value at ack", tval(r), d0);
      end
      model[r] = d0;
      repeat ($urandom_range(0, 4)) @(negedge hclk);
    end
    settle();
    for (int r = 0; r < NR; r++) begin
      bus_read(3'(r), rd, lat);
      chk(rd == model[r], "R6 random shadow", rd, model[r]);
      chk(tval(r) == model[r], "R4 random final timer value", tval(r), model[r]);
    end
    finish_run();
  end
endmodule